// File: doc/BRIEF.md
# ADC Output Test Pattern Generator

This block stands between the converter core and the output serializer. It replaces the sample words with a known digital pattern, so that a receiver can prove that it captures data correctly and with enough timing margin. A 4-bit mode code picks one of twelve patterns. The code 0 and the unused codes pass the live converter samples through unchanged.

One registered word leaves the block on every sample clock. Some patterns are a single word. Others swap between two words on successive samples, and every change of the mode code restarts them on their first word. A resolution input shortens the fixed words to 10 bits, right-justified on the 12-bit bus.

A format input turns the eligible patterns from offset binary into twos complement: the midscale and full-scale words, and the two pseudorandom words. It does this by inverting the top bit of the active width. An attached generator supplies the long and short pseudorandom words. Four 8-bit register values hold two user words.

Top module: `tpg_top`

## Requirements
- R1: While rst_ni is low, data_o is 0. After reset the block is in pass-through.
- R2: With mode code 0, or any code from 13 to 15, data_o equals adc_i from one clock earlier. The resolution and format inputs have no effect in these codes. Every output word is registered: it reflects the inputs present at the preceding rising clock edge.
- R3: Codes 1, 2 and 3 give midscale, positive full scale and negative full scale. These are 0x800, 0xFFF and 0x000 at 12 bits, and 0x200, 0x3FF and 0x000 at 10 bits. With twos_i high, the top bit of the active width is inverted (bit 11 at 12 bits, bit 9 at 10 bits).
- R4: Code 4 swaps 0xAAA and 0x555 (0x2AA and 0x155 at 10 bits) on successive samples. twos_i has no effect.
- R5: Code 7 swaps all ones (0xFFF, or 0x3FF at 10 bits) and 0x000 on successive samples. Code 9 gives 0xAAA (0x2AA at 10 bits) on every sample. twos_i has no effect on either code.
- R6: Code 8 swaps user word 1 and user word 2 on successive samples. User word 1 is the low 12 bits of {usr1_hi_i, usr1_lo_i}, and user word 2 is the low 12 bits of {usr2_hi_i, usr2_lo_i}. At 10 bits each word is the low 10 bits of the same value. twos_i has no effect.
- R7: Code 10 gives 0x07F (0x03F at 10 bits). Code 11 gives 0x000. Code 12 gives 0x867 (0x233 at 10 bits). twos_i has no effect on these codes.
- R8: Code 5 gives pn_long_i and code 6 gives pn_short_i, always at the full 12 bits whatever res10_i is. With twos_i high, bit 11 is inverted.
- R9: With res10_i high, every code except 0, 5, 6 and 13 to 15 drives data_o[11:10] to 0.
- R10: The first sample after any change of the mode code is the first word of a two-word pattern. Later samples alternate for as long as the code holds, and a change of res10_i or twos_i does not restart the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 4 | Pattern select code |
| res10_i | input | 1 | Use 10-bit pattern words |
| twos_i | input | 1 | Convert eligible patterns to twos complement |
| adc_i | input | 12 | Live converter sample |
| pn_long_i | input | 12 | Word from the long pseudorandom source |
| pn_short_i | input | 12 | Word from the short pseudorandom source |
| usr1_hi_i | input | 8 | User word 1, high byte |
| usr1_lo_i | input | 8 | User word 1, low byte |
| usr2_hi_i | input | 8 | User word 2, high byte |
| usr2_lo_i | input | 8 | User word 2, low byte |
| data_o | output | 12 | Registered output word |

## Verification
The bench sweeps every code under each pairing of resolution and format. A design that picks the wrong flip position, or that converts an ineligible pattern, shows a word that differs in bit 9 or bit 11. Random mode switches land at odd and even phases. A restart that is missing or misplaced leaves the second word where the first is due. Resolution and format also change while a two-word code holds, which catches a phase that restarts on the wrong input. The pseudorandom codes run at 10 bits, which exposes a design that truncates them or flips bit 9.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MD_OFF  = 4'd0,
    MD_MID  = 4'd1,
    MD_PFS  = 4'd2,
    MD_NFS  = 4'd3,
    MD_CHK  = 4'd4,
    MD_PNL  = 4'd5,
    MD_PNS  = 4'd6,
    MD_TOG  = 4'd7,
    MD_USR  = 4'd8,
    MD_ALT  = 4'd9,
    MD_SYNC = 4'd10,
    MD_ZERO = 4'd11,
    MD_MIX  = 4'd12
  } tpg_mode_e;

  function automatic logic is_pair(input logic [MODE_W-1:0] m);
    return (m == MD_CHK) || (m == MD_TOG) || (m == MD_USR);
  endfunction

  function automatic logic is_pn(input logic [MODE_W-1:0] m);
    return (m == MD_PNL) || (m == MD_PNS);
  endfunction
endpackage

// File: rtl/tpg_phase.sv
module tpg_phase
  import tpg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  output logic              ph_o
);
  logic [MODE_W-1:0] mode_q;
  logic              ph_q;

  // any code change restarts on word 1
  assign ph_o = (mode_i != mode_q) ? 1'b0 : ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MD_OFF;
      ph_q   <= 1'b0;
    end else begin
      mode_q <= mode_i;
      ph_q   <= is_pair(mode_i) ? ~ph_o : 1'b0;
    end
  end
endmodule

// File: rtl/tpg_word_sel.sv
module tpg_word_sel
  import tpg_pkg::*;
#(
  parameter int DW = 12,
  parameter int NW = 10,
  parameter int UW = 16,
  parameter logic [DW-1:0] MIX_W = DW'(12'h867),
  parameter logic [DW-1:0] MIX_N = DW'(12'h233)
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic              narrow_i,
  input  logic              ph_i,
  input  logic [DW-1:0]     adc_i,
  input  logic [DW-1:0]     pnl_i,
  input  logic [DW-1:0]     pns_i,
  input  logic [UW-1:0]     usr1_i,
  input  logic [UW-1:0]     usr2_i,
  output logic [DW-1:0]     word_o,
  output logic              fmt_o,
  output logic              pn_o
);
  localparam int SW_W = DW / 2 + 1;
  localparam int SW_N = NW / 2 + 1;
  localparam logic [DW-1:0] NMASK  = {{(DW-NW){1'b0}}, {NW{1'b1}}};
  localparam logic [DW-1:0] ONES   = {DW{1'b1}};
  localparam logic [DW-1:0] MID_W  = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] MID_N  = {{(DW-NW){1'b0}}, 1'b1, {(NW-1){1'b0}}};
  localparam logic [DW-1:0] SYNC_W = {{(DW-SW_W){1'b0}}, {SW_W{1'b1}}};
  localparam logic [DW-1:0] SYNC_N = {{(DW-SW_N){1'b0}}, {SW_N{1'b1}}};

  function automatic logic [DW-1:0] odd_bits();
    logic [DW-1:0] r;
    for (int i = 0; i < DW; i++) r[i] = (i % 2) == 1;
    return r;
  endfunction

  localparam logic [DW-1:0] ALT_W = odd_bits();

  logic [DW-1:0] wmask, u1, u2;

  assign wmask = narrow_i ? NMASK : ONES;
  assign u1    = DW'(usr1_i);
  assign u2    = DW'(usr2_i);

  always_comb begin
    word_o = adc_i;
    fmt_o  = 1'b0;
    pn_o   = 1'b0;
    case (mode_i)
      MD_MID:  begin word_o = narrow_i ? MID_N : MID_W; fmt_o = 1'b1; end
      MD_PFS:  begin word_o = wmask; fmt_o = 1'b1; end
      MD_NFS:  begin word_o = '0;    fmt_o = 1'b1; end
      MD_CHK:  word_o = (ph_i ? ~ALT_W : ALT_W) & wmask;
      MD_PNL:  begin word_o = pnl_i; fmt_o = 1'b1; pn_o = 1'b1; end
      MD_PNS:  begin word_o = pns_i; fmt_o = 1'b1; pn_o = 1'b1; end
      MD_TOG:  word_o = ph_i ? '0 : wmask;
      MD_USR:  word_o = (ph_i ? u2 : u1) & wmask;
      MD_ALT:  word_o = ALT_W & wmask;
      MD_SYNC: word_o = narrow_i ? SYNC_N : SYNC_W;
      MD_ZERO: word_o = '0;
      MD_MIX:  word_o = narrow_i ? MIX_N : MIX_W;
      default: word_o = adc_i;
    endcase
  end
endmodule

// File: rtl/tpg_fmt.sv
module tpg_fmt #(
  parameter int DW = 12,
  parameter int NW = 10
) (
  input  logic [DW-1:0] word_i,
  input  logic          en_i,
  input  logic          narrow_i,
  output logic [DW-1:0] word_o
);
  localparam logic [DW-1:0] TOP_W = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] TOP_N = {{(DW-NW){1'b0}}, 1'b1, {(NW-1){1'b0}}};

  logic [DW-1:0] flip;

  assign flip   = en_i ? (narrow_i ? TOP_N : TOP_W) : '0;
  assign word_o = word_i ^ flip;
endmodule

// File: rtl/tpg_top.sv
module tpg_top
  import tpg_pkg::*;
#(
  parameter int DW = 12,
  parameter int NW = 10,
  parameter int RW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              res10_i,
  input  logic              twos_i,
  input  logic [DW-1:0]     adc_i,
  input  logic [DW-1:0]     pn_long_i,
  input  logic [DW-1:0]     pn_short_i,
  input  logic [RW-1:0]     usr1_hi_i,
  input  logic [RW-1:0]     usr1_lo_i,
  input  logic [RW-1:0]     usr2_hi_i,
  input  logic [RW-1:0]     usr2_lo_i,
  output logic [DW-1:0]     data_o
);
  localparam int UW = 2 * RW;

  logic          ph, fmt_ok, pn_sel;
  logic [DW-1:0] raw_word, out_word;

  tpg_phase i_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode_i),
    .ph_o   (ph)
  );

  tpg_word_sel #(.DW(DW), .NW(NW), .UW(UW)) i_word_sel (
    .mode_i   (mode_i),
    .narrow_i (res10_i),
    .ph_i     (ph),
    .adc_i    (adc_i),
    .pnl_i    (pn_long_i),
    .pns_i    (pn_short_i),
    .usr1_i   ({usr1_hi_i, usr1_lo_i}),
    .usr2_i   ({usr2_hi_i, usr2_lo_i}),
    .word_o   (raw_word),
    .fmt_o    (fmt_ok),
    .pn_o     (pn_sel)
  );

  // PN words always run at full width
  tpg_fmt #(.DW(DW), .NW(NW)) i_fmt (
    .word_i   (raw_word),
    .en_i     (fmt_ok & twos_i),
    .narrow_i (res10_i & ~pn_sel),
    .word_o   (out_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_o <= '0;
    else         data_o <= out_word;
  end
endmodule

// File: rtl/tpg_checks.sv
module tpg_checks #(
  parameter int DW = 12,
  parameter int NW = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [3:0]    mode_i,
  input logic          res10_i,
  input logic          twos_i,
  input logic [DW-1:0] adc_i,
  input logic [DW-1:0] pn_long_i,
  input logic [DW-1:0] data_o
);
  logic [3:0] mode_prev;
  logic       seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_prev <= '0;
      seen_q    <= 1'b0;
    end else begin
      mode_prev <= mode_i;
      seen_q    <= 1'b1;
    end
  end

  always @(posedge clk_i) begin
    if (rst_ni === 1'b0) AST_RESET_ZERO: assert (data_o == '0); // R1
  end

  AST_PASS_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'd0 || mode_i >= 4'd13) |=> data_o == $past(adc_i)); // R2

  AST_ZERO_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'd11) |=> data_o == '0); // R7

  AST_PN_LONG_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'd5 && !twos_i) |=> data_o == $past(pn_long_i)); // R8

  AST_NARROW_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res10_i && mode_i != 4'd0 && mode_i != 4'd5 && mode_i != 4'd6 && mode_i <= 4'd12)
    |=> data_o[DW-1:NW] == '0); // R9

  AST_RESTART_WORD1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && mode_i == 4'd7 && mode_i != mode_prev && !res10_i)
    |=> data_o == {DW{1'b1}}); // R10
endmodule

bind tpg_top tpg_checks #(.DW(DW), .NW(NW)) i_checks (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mode_i    (mode_i),
  .res10_i   (res10_i),
  .twos_i    (twos_i),
  .adc_i     (adc_i),
  .pn_long_i (pn_long_i),
  .data_o    (data_o)
);

// File: tb/test_tpg_top.sv
`timescale 1ns/1ps
module test_tpg_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  mode = '0;
  logic        res10 = 1'b0, twos = 1'b0;
  logic [11:0] adc = '0, pnl = '0, pns = '0;
  logic [7:0]  u1h = '0, u1l = '0, u2h = '0, u2l = '0;
  logic [11:0] data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // model state
  int          prev_m = 0;
  bit          ph = 0;
  bit          have_exp = 0;
  logic [11:0] exp_w;
  string       exp_tag;
  bit          exp_narrow;

  always #2.5 clk = ~clk;

  tpg_top i_tpg_top (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .res10_i(res10), .twos_i(twos),
    .adc_i(adc), .pn_long_i(pnl), .pn_short_i(pns),
    .usr1_hi_i(u1h), .usr1_lo_i(u1l), .usr2_hi_i(u2h), .usr2_lo_i(u2l),
    .data_o(data)
  );

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s mode=%0d res10=%0b twos=%0b actual=%03h expected=%03h",
               tag, mode, res10, twos, act, expv);
    end
  endtask

  function automatic bit pair_mode(input int m);
    return m == 4 || m == 7 || m == 8;
  endfunction

  // one sample: check the previous word, then apply new inputs
  task automatic step(input int m, input bit n, input bit t);
    bit          changed, p, fm, fullw;
    logic [11:0] w, msk, w1, w2;
    @(negedge clk);
    if (have_exp) begin
      check(exp_tag, data, exp_w);
      if (exp_narrow) check("R9", {data[11:10], 10'h0}, 12'h0);
    end
    mode = 4'(m); res10 = n; twos = t;
    adc = 12'($urandom); pnl = 12'($urandom); pns = 12'($urandom);
    u1h = 8'($urandom); u1l = 8'($urandom); u2h = 8'($urandom); u2l = 8'($urandom);
    changed = (m != prev_m);
    p = changed ? 1'b0 : ph;
    msk = n ? 12'h3FF : 12'hFFF;
    w1 = {u1h[3:0], u1l} & msk;
    w2 = {u2h[3:0], u2l} & msk;
    fm = 0; fullw = 0;
    case (m)
      1: begin w = n ? 12'h200 : 12'h800; fm = 1; exp_tag = "R3"; end
      2: begin w = n ? 12'h3FF : 12'hFFF; fm = 1; exp_tag = "R3"; end
      3: begin w = 12'h000; fm = 1; exp_tag = "R3"; end
      4: begin w = p ? (n ? 12'h155 : 12'h555) : (n ? 12'h2AA : 12'hAAA); exp_tag = "R4"; end
      5: begin w = pnl; fm = 1; fullw = 1; exp_tag = "R8"; end
      6: begin w = pns; fm = 1; fullw = 1; exp_tag = "R8"; end
      7: begin w = p ? 12'h000 : (n ? 12'h3FF : 12'hFFF); exp_tag = "R5"; end
      8: begin w = p ? w2 : w1; exp_tag = "R6"; end
      9: begin w = n ? 12'h2AA : 12'hAAA; exp_tag = "R5"; end
      10: begin w = n ? 12'h03F : 12'h07F; exp_tag = "R7"; end
      11: begin w = 12'h000; exp_tag = "R7"; end
      12: begin w = n ? 12'h233 : 12'h867; exp_tag = "R7"; end
      default: begin w = adc; exp_tag = "R2"; end
    endcase
    if (fm && t) w[(fullw || !n) ? 11 : 9] = ~w[(fullw || !n) ? 11 : 9];
    if (changed && pair_mode(m)) exp_tag = "R10";
    exp_narrow = n && !(m == 0 || m == 5 || m == 6 || m >= 13);
    exp_w = w;
    have_exp = 1;
    ph = pair_mode(m) ? ~p : 1'b0;
    prev_m = m;
  endtask

  initial begin
    #150000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", data, 12'h000);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1", data, 12'h000);
    // full sweep: code held across resolution/format changes
    for (int m = 0; m < 16; m++)
      for (int c = 0; c < 4; c++)
        for (int k = 0; k < 5; k++) step(m, c[1], c[0]);
    // restarts at odd and even phases
    for (int k = 0; k < 3; k++) step(4, 0, 0);
    for (int k = 0; k < 2; k++) step(7, 0, 0);
    for (int k = 0; k < 3; k++) step(4, 1, 1);
    for (int k = 0; k < 4; k++) step(8, 0, 1);
    step(13, 0, 0);
    for (int k = 0; k < 3; k++) step(8, 1, 0);
    // random walk
    begin
      int m = 0;
      for (int k = 0; k < 3000; k++) begin
        if ($urandom_range(3) == 0) m = $urandom_range(15);
        step(m, 1'($urandom), 1'($urandom));
      end
    end
    step(0, 0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule